// File: doc/BRIEF.md
# Debug Path Mode Selector

This block is the steering logic inside a debug adapter that links a USB serial engine, an on-board microcontroller and an external 20-pin JTAG/SWD header. It picks one of three debug paths:

- **Local:** the engine debugs the on-board device.
- **Outbound:** the engine drives a target plugged into the header.
- **Inbound:** a debugger plugged into the header reaches the on-board device.

The selection comes from two inputs. One is a cable-presence line that is active low. The other is a debug-out request from the engine. Both are synchronized and filtered before the mode is allowed to change. The block routes the clock, mode/data, data-in and data-out lines to match the selected path. It also steers the SWDIO direction enable when SWD is selected.

The block has three more jobs. It can replace the UART transmit stream on the virtual COM line with the serial-wire trace stream. It merges the reset sources into one active-low target reset. It releases every target-facing output while the hibernate input is low.

All target-facing lines are presented as a value and an output-enable pair, so the pad ring adds the actual tristate buffers. Every path is a plain level signal. None of them is a stream, so the block has no handshake.

Top module: `dbg_path_sel`

## Requirements
- R1: After the block's reset, `mode_o` reads 2'b01 (local), `dbg_out_led` is 0 and no header output is enabled. `mode_o` never reads 2'b00.
- R2: With cable present (`cable_det_n`=0) and `dbgout_req`=1, the mode becomes 2'b10 (outbound). In that mode `dbg_out_led`=1 and the local test reset `loc_trst_n` is driven 0.
- R3: With cable present and `dbgout_req`=0, the mode becomes 2'b11 (inbound).
- R4: With no cable (`cable_det_n`=1), the mode becomes 2'b01 whatever `dbgout_req` is.
- R5: The inputs pass a two-flop synchronizer. The mode changes only after a new condition has been seen on 4 consecutive clocks. A condition held for 2 clocks changes nothing, and no change is visible 3 clocks after an input moves. Two mode changes are always at least 4 clocks apart.
- R6: In mode 2'b01, `loc_tck_o`, `loc_tms_o` and `loc_tdi_o` follow `eng_tck`, `eng_tms_o` and `eng_tdi`. `eng_tdo` follows `loc_tdo_i`. All four header enables are 0.
- R7: In mode 2'b10, the header outputs `hdr_tck_o`, `hdr_tms_o` and `hdr_tdi_o` follow the engine and are enabled. `eng_tdo` follows `hdr_tdo_i`. `loc_tck_o` is held 0.
- R8: In mode 2'b11, with JTAG selected, the local clock, TMS and TDI follow `hdr_tck_i`, `hdr_tms_i` and `hdr_tdi_i`. `hdr_tdo_o` follows `loc_tdo_i` with `hdr_tdo_oe`=1. `eng_tdo` is 0 and `hdr_tck_oe` is 0.
- R9: With `swd_sel`=1 (SWD), the enable of the TMS/SWDIO line that faces the active target follows `eng_swdio_oe`. This is `loc_tms_oe` in mode 2'b01 and `hdr_tms_oe` in mode 2'b10. `eng_swdio_i` returns that line's input. In mode 2'b11 with SWD, `loc_tms_oe` is 0.
- R10: With `trace_en`=1, `vcp_tx` carries the trace stream. The stream is `hdr_tdo_i` in mode 2'b10 and `loc_tdo_i` in the other modes. With `trace_en`=0, `vcp_tx` follows `uart_tx`.
- R11: `loc_rst_n` is 0 for the first 16 clocks after the block's reset is released. It is also 0 while `rst_sw_n`=0 and while `sys_rst_req`=1, and it is 1 otherwise.
- R12: While `hib_n`=0, every target-facing enable is 0 in every mode. These are `loc_tck_oe`, `loc_tms_oe`, `loc_tdi_oe`, `loc_trst_oe`, `loc_rst_oe`, `hdr_tck_oe`, `hdr_tms_oe`, `hdr_tdi_oe` and `hdr_tdo_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for detection and power-on count |
| rst_n | input | 1 | Block reset, active low |
| cable_det_n | input | 1 | Header cable present when 0 |
| dbgout_req | input | 1 | Engine asks for outbound debugging |
| swd_sel | input | 1 | 1 selects SWD routing, 0 selects JTAG |
| trace_en | input | 1 | Put trace stream on the virtual COM line |
| rst_sw_n | input | 1 | Reset push switch, active low |
| sys_rst_req | input | 1 | Engine requests a target system reset |
| hib_n | input | 1 | Hibernate, active low; releases target outputs |
| eng_tck | input | 1 | Engine clock (TCK/SWCLK) |
| eng_tms_o | input | 1 | Engine TMS / SWDIO out value |
| eng_swdio_oe | input | 1 | Engine SWDIO drive direction |
| eng_tdi | input | 1 | Engine TDI |
| eng_tdo | output | 1 | TDO returned to the engine |
| eng_swdio_i | output | 1 | SWDIO value returned to the engine |
| loc_tck_o | output | 1 | Local device clock value |
| loc_tck_oe | output | 1 | Local clock enable |
| loc_tms_o | output | 1 | Local TMS/SWDIO value |
| loc_tms_oe | output | 1 | Local TMS/SWDIO enable |
| loc_tms_i | input | 1 | Local TMS/SWDIO pad input |
| loc_tdi_o | output | 1 | Local TDI value |
| loc_tdi_oe | output | 1 | Local TDI enable |
| loc_tdo_i | input | 1 | Local TDO/SWO |
| loc_trst_n | output | 1 | Local test reset value, active low |
| loc_trst_oe | output | 1 | Local test reset enable |
| loc_rst_n | output | 1 | Local system reset value, active low |
| loc_rst_oe | output | 1 | Local system reset enable |
| hdr_tck_o | output | 1 | Header clock value |
| hdr_tck_oe | output | 1 | Header clock enable |
| hdr_tck_i | input | 1 | Header clock input |
| hdr_tms_o | output | 1 | Header TMS/SWDIO value |
| hdr_tms_oe | output | 1 | Header TMS/SWDIO enable |
| hdr_tms_i | input | 1 | Header TMS/SWDIO input |
| hdr_tdi_o | output | 1 | Header TDI value |
| hdr_tdi_oe | output | 1 | Header TDI enable |
| hdr_tdi_i | input | 1 | Header TDI input |
| hdr_tdo_o | output | 1 | Header TDO value |
| hdr_tdo_oe | output | 1 | Header TDO enable |
| hdr_tdo_i | input | 1 | Header TDO/SWO input |
| uart_tx | input | 1 | UART transmit data |
| vcp_tx | output | 1 | Virtual COM transmit line |
| dbg_out_led | output | 1 | Outbound indicator |
| mode_o | output | 2 | Current mode: 01 local, 10 outbound, 11 inbound |

## Verification
Several rules hold on every clock, so the bound checker watches them continuously:

- Hibernate releases all nine enables.
- The indicator matches the outbound mode.
- The local test reset is held while outbound.
- The header is idle in local mode.
- Mode changes are at least the filter length apart.
- The target reset covers the power-on window.

Other behaviour can only be shown by the directed scenarios:

- The actual mode decoded from each cable/request combination.
- The rejection of a two-clock glitch.
- The signal-by-signal routing in each mode.
- SWD direction steering.
- Trace substitution on the COM line.
- Each separate reset source.

// File: rtl/dbg_path_pkg.sv
package dbg_path_pkg;
  typedef enum logic [1:0] {
    M_LOCAL = 2'b01,
    M_OUT   = 2'b10,
    M_IN    = 2'b11
  } dbg_mode_e;
endpackage

// File: rtl/dbg_sync.sv
// Multi-stage level synchronizer, reset to zero.
module dbg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dbg_mode_det.sv
// Decodes cable presence and the outbound request into a mode,
// accepting a new mode only after it persists STABLE_CYC clocks.
module dbg_mode_det
  import dbg_path_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cable_det_n,
  input  logic      dbgout_req,
  output dbg_mode_e mode
);
  localparam int CW = $clog2(STABLE_CYC + 1);

  logic [1:0] raw, syn;
  assign raw = {dbgout_req, ~cable_det_n};

  dbg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw),
    .q    (syn)
  );

  dbg_mode_e       cand, pend_q, mode_q;
  logic [CW-1:0]   cnt_q;

  always_comb begin
    if (!syn[0])     cand = M_LOCAL;
    else if (syn[1]) cand = M_OUT;
    else             cand = M_IN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= M_LOCAL;
      mode_q <= M_LOCAL;
      cnt_q  <= '0;
    end else begin
      if (cand != pend_q) begin
        pend_q <= cand;
        cnt_q  <= CW'(1);
      end else if (cnt_q < CW'(STABLE_CYC)) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (cand == pend_q && cnt_q >= CW'(STABLE_CYC - 1)) mode_q <= pend_q;
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/dbg_por.sv
// Power-on stretch plus merge of the reset sources (active-low result).
module dbg_por #(
  parameter int POR_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_sw_n,
  input  logic sys_rst_req,
  output logic tgt_rst_n
);
  logic por_act;

  if (POR_CYC > 0) begin : g_cnt
    localparam int PW = $clog2(POR_CYC + 1);
    logic [PW-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (cnt_q < PW'(POR_CYC))   cnt_q <= cnt_q + 1'b1;
    end
    assign por_act = (cnt_q < PW'(POR_CYC));
  end else begin : g_none
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign por_act = 1'b0;
  end

  assign tgt_rst_n = ~(por_act | ~rst_sw_n | sys_rst_req);
endmodule

// File: rtl/dbg_route.sv
// Combinational steering of debug, trace and enables; hibernate gates
// every target-facing enable.
module dbg_route
  import dbg_path_pkg::*;
(
  input  dbg_mode_e mode,
  input  logic      swd_sel,
  input  logic      trace_en,
  input  logic      hib_n,
  input  logic      eng_tck,
  input  logic      eng_tms_o,
  input  logic      eng_swdio_oe,
  input  logic      eng_tdi,
  output logic      eng_tdo,
  output logic      eng_swdio_i,
  output logic      loc_tck_o,
  output logic      loc_tck_oe,
  output logic      loc_tms_o,
  output logic      loc_tms_oe,
  input  logic      loc_tms_i,
  output logic      loc_tdi_o,
  output logic      loc_tdi_oe,
  input  logic      loc_tdo_i,
  output logic      loc_trst_n,
  output logic      loc_trst_oe,
  output logic      loc_rst_oe,
  output logic      hdr_tck_o,
  output logic      hdr_tck_oe,
  input  logic      hdr_tck_i,
  output logic      hdr_tms_o,
  output logic      hdr_tms_oe,
  input  logic      hdr_tms_i,
  output logic      hdr_tdi_o,
  output logic      hdr_tdi_oe,
  input  logic      hdr_tdi_i,
  output logic      hdr_tdo_o,
  output logic      hdr_tdo_oe,
  input  logic      hdr_tdo_i,
  input  logic      uart_tx,
  output logic      vcp_tx
);
  localparam int NEN = 9;

  logic [NEN-1:0] en_raw;
  logic           tms_dir;
  logic           swo_src;

  assign tms_dir = swd_sel ? eng_swdio_oe : 1'b1;

  always_comb begin
    loc_tck_o   = 1'b0;
    loc_tms_o   = 1'b0;
    loc_tdi_o   = 1'b0;
    loc_trst_n  = 1'b1;
    hdr_tck_o   = 1'b0;
    hdr_tms_o   = 1'b0;
    hdr_tdi_o   = 1'b0;
    hdr_tdo_o   = 1'b0;
    eng_tdo     = 1'b0;
    eng_swdio_i = 1'b0;
    swo_src     = loc_tdo_i;
    // order: loc tck,tms,tdi,trst,rst, hdr tck,tms,tdi,tdo
    en_raw      = 9'b111_11_0000;
    case (mode)
      M_OUT: begin
        loc_trst_n  = 1'b0;
        hdr_tck_o   = eng_tck;
        hdr_tms_o   = eng_tms_o;
        hdr_tdi_o   = eng_tdi;
        eng_tdo     = hdr_tdo_i;
        eng_swdio_i = hdr_tms_i;
        swo_src     = hdr_tdo_i;
        en_raw      = {5'b11111, 1'b1, tms_dir, 1'b1, 1'b0};
      end
      M_IN: begin
        loc_tck_o   = hdr_tck_i;
        loc_tms_o   = hdr_tms_i;
        loc_tdi_o   = hdr_tdi_i;
        hdr_tdo_o   = loc_tdo_i;
        en_raw      = {1'b1, ~swd_sel, 3'b111, 4'b0001};
      end
      default: begin
        loc_tck_o   = eng_tck;
        loc_tms_o   = eng_tms_o;
        loc_tdi_o   = eng_tdi;
        eng_tdo     = loc_tdo_i;
        eng_swdio_i = loc_tms_i;
        en_raw      = {1'b1, tms_dir, 3'b111, 4'b0000};
      end
    endcase
  end

  logic [NEN-1:0] en_gated;
  assign en_gated = en_raw & {NEN{hib_n}};
  assign {loc_tck_oe, loc_tms_oe, loc_tdi_oe, loc_trst_oe, loc_rst_oe,
          hdr_tck_oe, hdr_tms_oe, hdr_tdi_oe, hdr_tdo_oe} = en_gated;

  assign vcp_tx = trace_en ? swo_src : uart_tx;
endmodule

// File: rtl/dbg_path_sel.sv
module dbg_path_sel
  import dbg_path_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 4,
  parameter int POR_CYC     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cable_det_n,
  input  logic       dbgout_req,
  input  logic       swd_sel,
  input  logic       trace_en,
  input  logic       rst_sw_n,
  input  logic       sys_rst_req,
  input  logic       hib_n,
  input  logic       eng_tck,
  input  logic       eng_tms_o,
  input  logic       eng_swdio_oe,
  input  logic       eng_tdi,
  output logic       eng_tdo,
  output logic       eng_swdio_i,
  output logic       loc_tck_o,
  output logic       loc_tck_oe,
  output logic       loc_tms_o,
  output logic       loc_tms_oe,
  input  logic       loc_tms_i,
  output logic       loc_tdi_o,
  output logic       loc_tdi_oe,
  input  logic       loc_tdo_i,
  output logic       loc_trst_n,
  output logic       loc_trst_oe,
  output logic       loc_rst_n,
  output logic       loc_rst_oe,
  output logic       hdr_tck_o,
  output logic       hdr_tck_oe,
  input  logic       hdr_tck_i,
  output logic       hdr_tms_o,
  output logic       hdr_tms_oe,
  input  logic       hdr_tms_i,
  output logic       hdr_tdi_o,
  output logic       hdr_tdi_oe,
  input  logic       hdr_tdi_i,
  output logic       hdr_tdo_o,
  output logic       hdr_tdo_oe,
  input  logic       hdr_tdo_i,
  input  logic       uart_tx,
  output logic       vcp_tx,
  output logic       dbg_out_led,
  output logic [1:0] mode_o
);
  dbg_mode_e mode;

  dbg_mode_det #(.SYNC_STAGES(SYNC_STAGES), .STABLE_CYC(STABLE_CYC)) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .cable_det_n(cable_det_n),
    .dbgout_req (dbgout_req),
    .mode       (mode)
  );

  dbg_por #(.POR_CYC(POR_CYC)) u_por (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sw_n   (rst_sw_n),
    .sys_rst_req(sys_rst_req),
    .tgt_rst_n  (loc_rst_n)
  );

  dbg_route u_route (
    .mode        (mode),
    .swd_sel     (swd_sel),
    .trace_en    (trace_en),
    .hib_n       (hib_n),
    .eng_tck     (eng_tck),
    .eng_tms_o   (eng_tms_o),
    .eng_swdio_oe(eng_swdio_oe),
    .eng_tdi     (eng_tdi),
    .eng_tdo     (eng_tdo),
    .eng_swdio_i (eng_swdio_i),
    .loc_tck_o   (loc_tck_o),
    .loc_tck_oe  (loc_tck_oe),
    .loc_tms_o   (loc_tms_o),
    .loc_tms_oe  (loc_tms_oe),
    .loc_tms_i   (loc_tms_i),
    .loc_tdi_o   (loc_tdi_o),
    .loc_tdi_oe  (loc_tdi_oe),
    .loc_tdo_i   (loc_tdo_i),
    .loc_trst_n  (loc_trst_n),
    .loc_trst_oe (loc_trst_oe),
    .loc_rst_oe  (loc_rst_oe),
    .hdr_tck_o   (hdr_tck_o),
    .hdr_tck_oe  (hdr_tck_oe),
    .hdr_tck_i   (hdr_tck_i),
    .hdr_tms_o   (hdr_tms_o),
    .hdr_tms_oe  (hdr_tms_oe),
    .hdr_tms_i   (hdr_tms_i),
    .hdr_tdi_o   (hdr_tdi_o),
    .hdr_tdi_oe  (hdr_tdi_oe),
    .hdr_tdi_i   (hdr_tdi_i),
    .hdr_tdo_o   (hdr_tdo_o),
    .hdr_tdo_oe  (hdr_tdo_oe),
    .hdr_tdo_i   (hdr_tdo_i),
    .uart_tx     (uart_tx),
    .vcp_tx      (vcp_tx)
  );

  assign mode_o      = mode;
  assign dbg_out_led = (mode == M_OUT);
endmodule

// File: rtl/dbg_path_sel_chk.sv
module dbg_path_sel_chk #(
  parameter int STABLE_CYC = 4,
  parameter int POR_CYC    = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       hib_n,
  input logic [1:0] mode_o,
  input logic       dbg_out_led,
  input logic       loc_trst_n,
  input logic       loc_rst_n,
  input logic       loc_tck_oe,
  input logic       loc_tms_oe,
  input logic       loc_tdi_oe,
  input logic       loc_trst_oe,
  input logic       loc_rst_oe,
  input logic       hdr_tck_oe,
  input logic       hdr_tms_oe,
  input logic       hdr_tdi_oe,
  input logic       hdr_tdo_oe
);
  localparam int GW = $clog2(STABLE_CYC + 1);
  localparam int PW = $clog2(POR_CYC + 1);

  logic [8:0] oe_all;
  assign oe_all = {loc_tck_oe, loc_tms_oe, loc_tdi_oe, loc_trst_oe, loc_rst_oe,
                   hdr_tck_oe, hdr_tms_oe, hdr_tdi_oe, hdr_tdo_oe};

  logic [1:0]    prev_q;
  logic [GW-1:0] gap_q;
  logic [PW-1:0] up_q;
  logic          chg;
  assign chg = (mode_o != prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 2'b01;
      gap_q  <= GW'(STABLE_CYC);
      up_q   <= '0;
    end else begin
      prev_q <= mode_o;
      if (chg)                             gap_q <= GW'(1);
      else if (gap_q < GW'(STABLE_CYC))    gap_q <= gap_q + 1'b1;
      if (up_q < PW'(POR_CYC))             up_q <= up_q + 1'b1;
    end
  end

  // R12
  hib_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hib_n |-> (oe_all == 9'd0));

  // R1
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b00);

  // R2
  led_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_out_led == (mode_o == 2'b10));

  // R2
  trst_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hib_n && mode_o == 2'b10) |-> (!loc_trst_n && loc_trst_oe));

  // R6
  hdr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b01) |-> !(hdr_tck_oe | hdr_tms_oe | hdr_tdi_oe | hdr_tdo_oe));

  // R5
  mode_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> (gap_q >= GW'(STABLE_CYC)));

  // R11
  por_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q < PW'(POR_CYC)) |-> !loc_rst_n);
endmodule

bind dbg_path_sel dbg_path_sel_chk #(
  .STABLE_CYC(STABLE_CYC),
  .POR_CYC   (POR_CYC)
) u_chk (.*);

// File: tb/dbg_path_sel_bench.sv
module dbg_path_sel_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cable_det_n = 1'b1, dbgout_req = 1'b0, swd_sel = 1'b0, trace_en = 1'b0;
  logic rst_sw_n = 1'b1, sys_rst_req = 1'b0, hib_n = 1'b1;
  logic eng_tck = 1'b0, eng_tms_o = 1'b0, eng_swdio_oe = 1'b0, eng_tdi = 1'b0;
  logic loc_tms_i = 1'b0, loc_tdo_i = 1'b0;
  logic hdr_tck_i = 1'b0, hdr_tms_i = 1'b0, hdr_tdi_i = 1'b0, hdr_tdo_i = 1'b0;
  logic uart_tx = 1'b0;
  logic eng_tdo, eng_swdio_i;
  logic loc_tck_o, loc_tck_oe, loc_tms_o, loc_tms_oe, loc_tdi_o, loc_tdi_oe;
  logic loc_trst_n, loc_trst_oe, loc_rst_n, loc_rst_oe;
  logic hdr_tck_o, hdr_tck_oe, hdr_tms_o, hdr_tms_oe, hdr_tdi_o, hdr_tdi_oe;
  logic hdr_tdo_o, hdr_tdo_oe, vcp_tx, dbg_out_led;
  logic [1:0] mode_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dbg_path_sel u_dbg_path_sel (.*);

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic logic [8:0] oe_vec();
    return {loc_tck_oe, loc_tms_oe, loc_tdi_oe, loc_trst_oe, loc_rst_oe,
            hdr_tck_oe, hdr_tms_oe, hdr_tdi_oe, hdr_tdo_oe};
  endfunction

  task automatic t_reset;
    step(3);
    check("R1 mode in reset", 9'(mode_o), 9'h1);
    check("R1 led in reset", 9'(dbg_out_led), 9'h0);
    check("R1 header enables", 9'({hdr_tck_oe, hdr_tms_oe, hdr_tdi_oe, hdr_tdo_oe}), 9'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_por;
    step(8);
    check("R11 power-on hold", 9'(loc_rst_n), 9'h0);
    step(12);
    check("R11 power-on release", 9'(loc_rst_n), 9'h1);
    check("R1 mode after reset", 9'(mode_o), 9'h1);
  endtask

  task automatic t_local_jtag;
    eng_tck = 1; eng_tms_o = 1; eng_tdi = 1; loc_tdo_i = 1;
    step(1);
    check("R6 loc tck", 9'(loc_tck_o), 9'h1);
    check("R6 loc tms", 9'({loc_tms_o, loc_tms_oe}), 9'h3);
    check("R6 loc tdi", 9'(loc_tdi_o), 9'h1);
    check("R6 eng tdo", 9'(eng_tdo), 9'h1);
    eng_tck = 0; eng_tdi = 0; loc_tdo_i = 0;
    step(1);
    check("R6 pattern2", 9'({loc_tck_o, loc_tms_o, loc_tdi_o, eng_tdo}), 9'b0100);
    check("R6 header idle", 9'({hdr_tck_oe, hdr_tms_oe, hdr_tdi_oe, hdr_tdo_oe}), 9'h0);
    check("R6 trst released", 9'(loc_trst_n), 9'h1);
  endtask

  task automatic t_glitch_then_in;
    cable_det_n = 0;
    step(2);
    cable_det_n = 1;
    step(12);
    check("R5 glitch rejected", 9'(mode_o), 9'h1);
    cable_det_n = 0;
    step(3);
    check("R5 no early change", 9'(mode_o), 9'h1);
    step(12);
    check("R3 inbound mode", 9'(mode_o), 9'h3);
    check("R3 led off", 9'(dbg_out_led), 9'h0);
  endtask

  task automatic t_mode_in;
    hdr_tck_i = 1; hdr_tms_i = 1; hdr_tdi_i = 0; loc_tdo_i = 1;
    step(1);
    check("R8 loc tck", 9'(loc_tck_o), 9'h1);
    check("R8 loc tms", 9'({loc_tms_o, loc_tms_oe}), 9'h3);
    check("R8 loc tdi", 9'(loc_tdi_o), 9'h0);
    check("R8 hdr tdo", 9'({hdr_tdo_o, hdr_tdo_oe}), 9'h3);
    check("R8 eng tdo quiet", 9'(eng_tdo), 9'h0);
    check("R8 hdr tck released", 9'(hdr_tck_oe), 9'h0);
    hdr_tck_i = 0; hdr_tdi_i = 1; loc_tdo_i = 0;
    step(1);
    check("R8 pattern2", 9'({loc_tck_o, loc_tdi_o, hdr_tdo_o}), 9'b010);
    swd_sel = 1;
    step(1);
    check("R9 inbound swd releases", 9'(loc_tms_oe), 9'h0);
    swd_sel = 0; hdr_tms_i = 0;
  endtask

  task automatic t_mode_out;
    dbgout_req = 1;
    step(12);
    check("R2 outbound mode", 9'(mode_o), 9'h2);
    check("R2 led on", 9'(dbg_out_led), 9'h1);
    check("R2 trst asserted", 9'({loc_trst_n, loc_trst_oe}), 9'h1);
    eng_tck = 1; eng_tms_o = 1; eng_tdi = 1; hdr_tdo_i = 1;
    step(1);
    check("R7 hdr tck", 9'({hdr_tck_o, hdr_tck_oe}), 9'h3);
    check("R7 hdr tms", 9'({hdr_tms_o, hdr_tms_oe}), 9'h3);
    check("R7 hdr tdi", 9'({hdr_tdi_o, hdr_tdi_oe}), 9'h3);
    check("R7 eng tdo", 9'(eng_tdo), 9'h1);
    check("R7 loc tck held", 9'(loc_tck_o), 9'h0);
    hdr_tdo_i = 0;
    step(1);
    check("R7 eng tdo low", 9'(eng_tdo), 9'h0);
  endtask

  task automatic t_swd_out;
    swd_sel = 1; eng_swdio_oe = 0; hdr_tms_i = 1;
    step(1);
    check("R9 hdr swdio read", 9'(hdr_tms_oe), 9'h0);
    check("R9 swdio return", 9'(eng_swdio_i), 9'h1);
    eng_swdio_oe = 1;
    step(1);
    check("R9 hdr swdio drive", 9'(hdr_tms_oe), 9'h1);
    swd_sel = 0; hdr_tms_i = 0;
  endtask

  task automatic t_trace_out;
    trace_en = 1; hdr_tdo_i = 1; loc_tdo_i = 0; uart_tx = 0;
    step(1);
    check("R10 trace outbound", 9'(vcp_tx), 9'h1);
    hdr_tdo_i = 0;
    step(1);
    check("R10 trace outbound low", 9'(vcp_tx), 9'h0);
    trace_en = 0; uart_tx = 1;
    step(1);
    check("R10 uart passthrough", 9'(vcp_tx), 9'h1);
    uart_tx = 0;
  endtask

  task automatic t_hib(input string tag, input logic [8:0] awake);
    hib_n = 0;
    step(1);
    check({"R12 float ", tag}, oe_vec(), 9'h0);
    hib_n = 1;
    step(1);
    check({"R12 restore ", tag}, oe_vec(), awake);
  endtask

  task automatic t_back_local;
    cable_det_n = 1;
    step(12);
    check("R4 local despite request", 9'(mode_o), 9'h1);
    check("R4 led off", 9'(dbg_out_led), 9'h0);
    swd_sel = 1; eng_swdio_oe = 1; loc_tms_i = 1;
    step(1);
    check("R9 loc swdio drive", 9'(loc_tms_oe), 9'h1);
    check("R9 loc swdio return", 9'(eng_swdio_i), 9'h1);
    eng_swdio_oe = 0;
    step(1);
    check("R9 loc swdio read", 9'(loc_tms_oe), 9'h0);
    swd_sel = 0;
    trace_en = 1; loc_tdo_i = 1; uart_tx = 0;
    step(1);
    check("R10 trace local", 9'(vcp_tx), 9'h1);
    trace_en = 0;
  endtask

  task automatic t_rst_src;
    rst_sw_n = 0;
    step(1);
    check("R11 switch reset", 9'(loc_rst_n), 9'h0);
    rst_sw_n = 1;
    step(1);
    check("R11 switch release", 9'(loc_rst_n), 9'h1);
    sys_rst_req = 1;
    step(1);
    check("R11 engine reset", 9'(loc_rst_n), 9'h0);
    sys_rst_req = 0;
    step(1);
    check("R11 engine release", 9'(loc_rst_n), 9'h1);
  endtask

  initial begin
    t_reset();
    t_por();
    t_local_jtag();
    t_hib("local", 9'b111_11_0000);
    t_glitch_then_in();
    t_mode_in();
    t_mode_out();
    t_swd_out();
    t_trace_out();
    t_hib("outbound", 9'b111_11_1111 & 9'b111_11_1110);
    t_back_local();
    t_rst_src();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule